// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-side engine of a 128K x 8 serial EEPROM that answers on a two-wire open-drain bus. A fast system clock samples the bus clock and data lines. The engine finds start and stop conditions and takes in the device address byte. When the address matches, it acknowledges by pulling the data line low. The data line is only ever pulled low through an active-high enable and is never driven high.

A write transfer carries two word-address bytes and then any number of data bytes. Each data byte goes out on a one-cycle write strobe, together with its word address, to a write buffer that sits outside this block. Reads fetch bytes through a synchronous memory read port, where data arrives one cycle after the enable. A read can be a current-address read, a random read made of a dummy write and a repeated start, or a sequential read that the master extends with acknowledges.

The state machine has eleven states:

- `ST_IDLE` waits for a start condition.
- `ST_DEV` shifts in the device byte.
- `ST_DEV` goes to `ST_DEV_ACK` on a match and back to `ST_IDLE` on a mismatch.
- `ST_DEV_ACK` goes to `ST_HI` for a write or to `ST_RD` for a read.
- The write path runs `ST_HI` -> `ST_HI_ACK` -> `ST_LO` -> `ST_LO_ACK` -> `ST_WR` <-> `ST_WR_ACK`.
- The read path runs `ST_RD` -> `ST_RD_ACK`. On a master acknowledge it returns to `ST_RD`. On a master not-acknowledge it goes to `ST_IDLE`.
- A start condition in any state goes to `ST_DEV`. A stop condition in any state goes to `ST_IDLE`.

Top module: `twi_eeprom_engine`

## Requirements
- R1: While reset is asserted and after it, `sda_oe`, `wr_valid` and `mem_rd_en` are low, and the word pointer is 0.
- R2: A start condition (SDA falling while SCL is high) begins device-byte reception from any state, including in the middle of a byte. A stop condition (SDA rising while SCL is high) returns the engine to idle from any state.
- R3: The device byte is sent MSB first and has the layout bits[7:4]=1010, bits[3:2]=00, bit[1]=P0 (word-address bit 16), bit[0]=R/W, where 1 means read. On a match, `sda_oe` is high through the ninth SCL pulse. On a mismatch, SDA stays released and the engine ignores the bus until the next start.
- R4: In a write transfer, both word-address bytes are acknowledged. The word pointer is loaded with {P0, high byte, low byte}.
- R5: Each write data byte is acknowledged. It is presented with `wr_valid` high for one cycle, with `wr_data` set to the byte and `wr_addr` set to the pointer.
- R6: After each write byte, pointer bits [7:0] increment modulo 256 and bits [16:8] are kept, so writes wrap within the 256-byte page.
- R7: A device byte with R/W=1 returns the byte at the pointer, MSB first, with each bit changed only after an SCL falling edge. P0 is ignored in a read device byte.
- R8: The pointer holds the last accessed address plus one and keeps that value across transfers, so a current-address read follows on from the previous read or write.
- R9: A random read is a write device byte, the two address bytes, a repeated start and a read device byte. It returns the byte at the loaded address and produces no write strobe.
- R10: In a sequential read, each master acknowledge (SDA low in the ninth clock) fetches and sends the next byte. Reads wrap from 0x1FFFF to 0x00000.
- R11: A master not-acknowledge ends the read. SDA stays released and the pointer does not advance again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| mem_rd_en | output | 1 | One-cycle read request to the array |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | ADDR_W | Word address of the write byte |
| wr_data | output | 8 | Received write byte |

## Verification
The bench builds the engine with ADDR_W=17 and a two-stage synchronizer. With these values the full 17-bit address is reachable, including P0 and the array-wide read wrap at 0x1FFFF, without any memory inside the engine. The bench models the array as a computed function of the address, so the byte expected at any address, including the wrap target, is known exactly. Page wrap on writes, aborts in the middle of a byte and rejected device bytes are driven as directed bus sequences.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/twi_word_ptr.sv
module twi_word_ptr #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_full,
    input  logic          inc_page,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (inc_full) ptr <= ptr + 1'b1;
        else if (inc_page) ptr[7:0] <= ptr[7:0] + 8'd1;
    end

    // R6
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page && !load && !inc_full |=>
            ptr[AW-1:8] == $past(ptr[AW-1:8]) && ptr[7:0] == $past(ptr[7:0]) + 8'd1);
    // R10
    array_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_full && !load && (&ptr) |=> ptr == '0);
endmodule

// File: rtl/twi_eeprom_engine.sv
module twi_eeprom_engine
    import twi_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int HI_W = ADDR_W - 9;

    eng_state_t        state;
    logic [3:0]        bitcnt;
    logic [7:0]        rx_sr, tx_sr, hi_q, rd_q;
    logic              p0_q, rd_pend;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_done, dev_match, ptr_load;
    logic [ADDR_W-1:0] ptr;

    twi_line_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_word_ptr #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val({p0_q, hi_q[HI_W-1:0], rx_sr}),
        .inc_full(mem_rd_en), .inc_page(wr_valid), .ptr(ptr)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign dev_match = (rx_sr[7:4] == DEV_TYPE) && (rx_sr[3:2] == 2'b00);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            hi_q    <= '0;
            p0_q    <= 1'b0;
            rd_pend <= 1'b0;
            rd_q    <= '0;
        end else begin
            rd_pend <= mem_rd_en;
            if (rd_pend) rd_q <= mem_rd_data;
            if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_DEV, ST_HI, ST_LO, ST_WR: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            rx_sr  <= {rx_sr[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            unique case (state)
                                ST_DEV: begin
                                    if (dev_match) begin
                                        if (!rx_sr[0]) p0_q <= rx_sr[1];
                                        state <= ST_DEV_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ST_HI: begin
                                    hi_q  <= rx_sr;
                                    state <= ST_HI_ACK;
                                end
                                ST_LO:   state <= ST_LO_ACK;
                                default: state <= ST_WR_ACK;
                            endcase
                        end
                    end
                    ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            unique case (state)
                                ST_DEV_ACK: begin
                                    if (rx_sr[0]) begin
                                        tx_sr <= rd_q;
                                        state <= ST_RD;
                                    end else begin
                                        state <= ST_HI;
                                    end
                                end
                                ST_HI_ACK: state <= ST_LO;
                                default:   state <= ST_WR;
                            endcase
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                bitcnt <= '0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx_sr  <= {tx_sr[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            tx_sr  <= rd_q;
                            bitcnt <= '0;
                            state  <= ST_RD;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        mem_rd_en = 1'b0;
        wr_valid  = 1'b0;
        ptr_load  = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:     sda_oe = ~tx_sr[7];
            ST_DEV:    mem_rd_en = byte_done && dev_match && rx_sr[0];
            ST_LO:     ptr_load  = byte_done;
            ST_WR:     wr_valid  = byte_done;
            ST_RD_ACK: mem_rd_en = scl_rise && !sda_s;
            default: ;
        endcase
    end

    assign mem_rd_addr = ptr;
    assign wr_addr     = ptr;
    assign wr_data     = rx_sr;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe && !wr_valid && !mem_rd_en);
    // R2
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_DEV && bitcnt == 4'd0);
    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);
    // R3
    reject_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DEV && byte_done && !dev_match && !start_det && !stop_det |=> !sda_oe);
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid && state == ST_WR_ACK);
endmodule

// File: tb/tb_twi_eeprom_engine.sv
module tb_twi_eeprom_engine;
    localparam int AW = 17;
    localparam int Q  = 10;
    // {start address, byte count} for random/sequential reads
    localparam logic [20:0] VECS [4] = '{
        {17'h00123, 4'd2}, {17'h100FF, 4'd3}, {17'h1FFFE, 4'd4}, {17'h0ABCD, 4'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, mem_rd_en, wr_valid;
    logic [AW-1:0] mem_rd_addr, wr_addr;
    logic [7:0] mem_q, wr_data;
    wire  sda_bus = m_sda & ~sda_oe;
    int   checks = 0, errors = 0, wr_n = 0;
    logic [AW-1:0] wr_a [16];
    logic [7:0]    wr_d [16];
    logic [AW-1:0] exp_ptr;
    bit   done = 0;

    always #2.5 clk = ~clk;

    twi_eeprom_engine #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_q),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h25};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_q <= memf(mem_rd_addr);
        if (rst_n && wr_valid) begin
            wr_a[wr_n[3:0]] <= wr_addr;
            wr_d[wr_n[3:0]] <= wr_data;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        m_scl = 0; hold(Q); m_sda = 1; hold(Q);
        m_scl = 1; hold(Q); m_sda = 0; hold(Q);
    endtask

    task automatic bus_stop;
        m_scl = 0; hold(Q); m_sda = 0; hold(Q);
        m_scl = 1; hold(Q); m_sda = 1; hold(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_scl = 0; hold(Q); m_sda = b[i]; hold(Q);
            m_scl = 1; hold(2 * Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_scl = 0; hold(Q); m_sda = 1; hold(Q);
        m_scl = 1; hold(Q); acked = (sda_bus == 1'b0); hold(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            m_scl = 0; hold(Q); m_sda = 1; hold(Q);
            m_scl = 1; hold(Q); d[i] = sda_bus; hold(Q);
        end
        m_scl = 0; hold(Q); m_sda = !mack; hold(Q);
        m_scl = 1; hold(2 * Q);
    endtask

    task automatic cur_read(input logic [7:0] devb, input string req);
        bit a; logic [7:0] d;
        bus_start;
        send_byte(devb, a);
        chk(a, req, a, 1);
        recv_byte(0, d);
        chk(d == memf(exp_ptr), req, d, memf(exp_ptr));
        exp_ptr = exp_ptr + 1'b1;
        bus_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a; logic [7:0] d; int w0;
        hold(5);
        // R1 outputs quiet in reset
        chk(!sda_oe && !wr_valid && !mem_rd_en, "R1", {sda_oe, wr_valid, mem_rd_en}, 0);
        rst_n = 1; hold(5);
        chk(!sda_oe, "R1", sda_oe, 0);
        exp_ptr = '0;
        cur_read(8'hA1, "R1 pointer 0 after reset");

        // R9 R10 table of random/sequential reads
        foreach (VECS[k]) begin
            logic [AW-1:0] ad; int n;
            ad = VECS[k][20:4]; n = int'(VECS[k][3:0]);
            w0 = wr_n;
            bus_start;
            send_byte({6'b101000, ad[16], 1'b0}, a); chk(a, "R3 dev ack", a, 1);
            send_byte(ad[15:8], a); chk(a, "R4 hi ack", a, 1);
            send_byte(ad[7:0], a);  chk(a, "R4 lo ack", a, 1);
            bus_start;
            send_byte(8'hA1, a); chk(a, "R9 read ack", a, 1);
            for (int i = 0; i < n; i++) begin
                logic [AW-1:0] ea;
                ea = ad + AW'(i);
                recv_byte(i != n - 1, d);
                chk(d == memf(ea), "R10 seq data", d, memf(ea));
            end
            bus_stop;
            chk(wr_n == w0, "R9 no write strobe", wr_n, w0);
            exp_ptr = ad + AW'(n);
        end

        // R8 current read continues, R7 P0 ignored on read
        cur_read(8'hA1, "R8 current read");
        cur_read(8'hA3, "R7 P0 ignored");

        // R5 R6 page write wraps within page
        w0 = wr_n;
        bus_start;
        send_byte(8'hA0, a); send_byte(8'h12, a); send_byte(8'hFE, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h11 * (i + 1), a);
            chk(a, "R5 data ack", a, 1);
        end
        bus_stop;
        chk(wr_n == w0 + 3, "R5 strobe count", wr_n, w0 + 3);
        chk(wr_a[w0[3:0]] == 17'h012FE && wr_d[w0[3:0]] == 8'h11, "R5 first",
            wr_a[w0[3:0]], 17'h012FE);
        chk(wr_a[w0[3:0] + 4'd1] == 17'h012FF, "R6 second", wr_a[w0[3:0] + 4'd1], 17'h012FF);
        chk(wr_a[w0[3:0] + 4'd2] == 17'h01200 && wr_d[w0[3:0] + 4'd2] == 8'h33, "R6 page wrap",
            wr_a[w0[3:0] + 4'd2], 17'h01200);
        exp_ptr = 17'h01201;
        cur_read(8'hA1, "R8 after write");

        // R3 rejected device bytes
        bus_start;
        send_byte(8'hA5, a); chk(!a, "R3 reserved bit set", a, 0);
        send_byte(8'h00, a); chk(!a, "R3 ignored until start", a, 0);
        bus_start;
        send_byte(8'hB1, a); chk(!a, "R3 wrong type", a, 0);
        bus_stop;
        chk(!sda_oe, "R3 released", sda_oe, 0);

        // R2 start in the middle of a byte
        bus_start; send_bits(8'hFF, 4);
        cur_read(8'hA1, "R2 start abort");
        // R2 stop in the middle of a byte
        bus_start; send_bits(8'hA0, 5); bus_stop;
        chk(!sda_oe, "R2 stop abort idle", sda_oe, 0);
        cur_read(8'hA1, "R2 after stop abort");

        // R11 NACK releases line, extra clock does not advance
        bus_start; send_byte(8'hA1, a);
        recv_byte(0, d);
        chk(d == memf(exp_ptr), "R11 data", d, memf(exp_ptr));
        exp_ptr = exp_ptr + 1'b1;
        m_scl = 0; hold(Q); m_scl = 1; hold(Q);
        chk(sda_bus == 1'b1, "R11 line released", sda_bus, 1);
        bus_stop;
        cur_read(8'hA1, "R11 pointer advanced once");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule